// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits behind the write path of a flash memory model. Each qualified bus write, an address with a data byte, is classified and fed to a state machine. The machine recognises unlock-protected program and erase sequences, an identification (autoselect) mode, erase suspend and resume, and a reset command. A malformed sequence drops the machine back to normal array reads.

The block does not time the program or erase algorithms. It issues a one-cycle start request with the operation, address and data. It then waits for a done input, with a fail qualifier, from the algorithm engine. While an erase is suspended it raises a hold level so the engine pauses. It also tells the read path, for the address being read, whether to return array data, status data or identification data.

A failed algorithm sets an error flag. The error flag and the identification mode both stay in place until a reset command is written. An external asynchronous reset, released synchronously inside the block, always restores read-array mode.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After the reset input is released the block is in read-array mode: rd_sel = 0 (0 array, 1 status, 2 identification), err_flag = 0, erase_hold = 0, alg_start = 0.
- R2: The write sequence 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0, followed by one more write (A, D), pulses alg_start for exactly one cycle, in the cycle after that write. With the pulse, alg_op = 1 (program), alg_addr = A and alg_data = D. rd_sel is 1 while the program runs, and a done with no fail returns the block to read-array mode.
- R3: A write with the wrong address or data inside a sequence returns the block to read-array mode, so the writes that follow do not complete the sequence.
- R4: A write of data 0xF0 at any address returns the block to read-array mode, including when it falls between the cycles of an erase sequence.
- R5: After 0x80 (following an unlock), a second unlock (0xAA@0x555, 0x55@0x2AA) followed by 0x10 at 0x555 starts a chip erase (alg_op = 3). A 0x30 at any address in that position starts a sector erase (alg_op = 2, alg_addr = that address). The sector is the top SECT_W bits of the address.
- R6: A 0xB0 write while an erase runs sets erase_hold. Reads in the erased sector, or at any address after a chip erase, then give rd_sel = 1, and reads elsewhere give rd_sel = 0. A 0x30 write while suspended clears erase_hold and the erase resumes (rd_sel = 1).
- R7: While suspended, an unlocked program can run. When it completes, the block returns to the suspended read behaviour with erase_hold still set.
- R8: Data 0xB0 and 0x30 written outside a running or suspended erase are ignored and leave the state unchanged. This also holds inside an unlock sequence, where the sequence continues afterwards. The exceptions are where 0x30 selects a sector erase and where the write is program data.
- R9: After an unlock and 0x90 the block gives rd_sel = 2. This holds through any write other than 0xF0, which returns it to read-array mode.
- R10: A done with fail set raises err_flag and gives rd_sel = 1. Only a 0xF0 write clears it.
- R11: While a program or an unsuspended erase runs, writes other than 0xB0 during an erase have no effect. This includes 0xF0.
- R12: In a cycle with neither a write nor a done, no start is issued and err_flag and erase_hold keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Qualified bus write this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| alg_done | input | 1 | Embedded algorithm finished |
| alg_fail | input | 1 | Algorithm failed, valid with alg_done |
| rd_addr | input | ADDR_W | Address currently read |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identification |
| alg_start | output | 1 | One-cycle algorithm start request |
| alg_op | output | 2 | 1 program, 2 sector erase, 3 chip erase |
| alg_addr | output | ADDR_W | Target address of the started operation |
| alg_data | output | 8 | Program data |
| erase_hold | output | 1 | Erase suspended, algorithm must pause |
| err_flag | output | 1 | Algorithm failure latched |

## Verification
The hardest case to reach is a program that completes inside an erase suspend, because it needs four stacked conditions. A sector erase must be running, then suspended, then an unlocked program started and finished, all while reads in and out of the suspended sector are still distinguished. The stimulus builds this step by step in one scenario, checking the read source for two addresses after each step. It then resumes the erase and completes it. A second hard spot is an ignored 0xB0 or 0x30 placed between unlock writes; the bench shows it was ignored by completing the program sequence afterwards.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_PWAIT,
    ST_EPRE, ST_EUL1, ST_EUL2,
    ST_PROG, ST_ERASE, ST_SUSP, ST_IDENT, ST_ERR
  } fsm_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0, OP_PROG = 2'd1, OP_SECT = 2'd2, OP_CHIP = 2'd3
  } alg_op_e;

  typedef enum logic [1:0] {
    RS_ARRAY = 2'd0, RS_STATUS = 2'd1, RS_IDENT = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic ul1;
    logic ul2;
    logic rst;
    logic prog;
    logic ident;
    logic epre;
    logic chip;
    logic sect;
    logic susp;
  } wr_cls_t;

  localparam logic [7:0] D_UL1   = 8'hAA;
  localparam logic [7:0] D_UL2   = 8'h55;
  localparam logic [7:0] D_RST   = 8'hF0;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_IDENT = 8'h90;
  localparam logic [7:0] D_EPRE  = 8'h80;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;
  localparam logic [7:0] D_SUSP  = 8'hB0;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output wr_cls_t           cls
);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(11'h555);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(11'h2AA);

  logic at_first, at_second;

  always_comb begin
    at_first  = (addr == A_FIRST);
    at_second = (addr == A_SECOND);
    cls.ul1   = at_first  && (data == D_UL1);
    cls.ul2   = at_second && (data == D_UL2);
    cls.rst   = (data == D_RST);
    cls.prog  = (data == D_PROG);
    cls.ident = (data == D_IDENT);
    cls.epre  = (data == D_EPRE);
    cls.chip  = at_first && (data == D_CHIP);
    cls.sect  = (data == D_SECT);
    cls.susp  = (data == D_SUSP);
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  wr_cls_t           cls,
  input  logic              alg_done,
  input  logic              alg_fail,
  output fsm_state_e        state,
  output logic              susp,
  output logic              chip_tgt,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              alg_start,
  output alg_op_e           alg_op,
  output logic [ADDR_W-1:0] alg_addr,
  output logic [7:0]        alg_data
);
  fsm_state_e        state_q, state_d, base;
  logic              susp_q, susp_d;
  logic              chip_q, chip_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              start_q, start_d;
  alg_op_e           op_q, op_d;
  logic [ADDR_W-1:0] aaddr_q, aaddr_d;
  logic [7:0]        adata_q, adata_d;
  logic              skip;
  logic              load_alg;

  always_comb begin
    base     = susp_q ? ST_SUSP : ST_READ;
    skip     = cls.susp || cls.sect;
    state_d  = state_q;
    susp_d   = susp_q;
    chip_d   = chip_q;
    tgt_d    = tgt_q;
    start_d  = 1'b0;
    op_d     = op_q;
    load_alg = 1'b0;
    if (wr_en) begin
      unique case (state_q)
        ST_READ: if (cls.ul1) state_d = ST_UL1;
        ST_SUSP: begin
          if (cls.sect) begin
            state_d = ST_ERASE;
            susp_d  = 1'b0;
          end else if (cls.ul1) begin
            state_d = ST_UL1;
          end
        end
        ST_UL1: if (!skip) state_d = cls.ul2 ? ST_UL2 : base;
        ST_UL2: begin
          if (!skip) begin
            if (cls.prog)                 state_d = ST_PWAIT;
            else if (cls.ident && !susp_q) state_d = ST_IDENT;
            else if (cls.epre && !susp_q)  state_d = ST_EPRE;
            else                           state_d = base;
          end
        end
        ST_PWAIT: begin
          state_d  = ST_PROG;
          start_d  = 1'b1;
          op_d     = OP_PROG;
          load_alg = 1'b1;
        end
        ST_EPRE: if (!skip) state_d = cls.ul1 ? ST_EUL1 : base;
        ST_EUL1: if (!skip) state_d = cls.ul2 ? ST_EUL2 : base;
        ST_EUL2: begin
          if (cls.chip || cls.sect) begin
            state_d  = ST_ERASE;
            start_d  = 1'b1;
            op_d     = cls.chip ? OP_CHIP : OP_SECT;
            load_alg = 1'b1;
            chip_d   = cls.chip;
            tgt_d    = wr_addr;
          end else if (!cls.susp) begin
            state_d = base;
          end
        end
        ST_ERASE: if (cls.susp && !alg_done) begin
          state_d = ST_SUSP;
          susp_d  = 1'b1;
        end
        ST_IDENT, ST_ERR: if (cls.rst) state_d = base;
        default: ;
      endcase
    end
    if (alg_done && (state_q == ST_PROG || state_q == ST_ERASE)) begin
      if (alg_fail)                state_d = ST_ERR;
      else if (state_q == ST_PROG) state_d = base;
      else                         state_d = ST_READ;
    end
  end

  always_comb begin
    aaddr_d = load_alg ? wr_addr : aaddr_q;
    adata_d = load_alg ? ((state_q == ST_PWAIT) ? wr_data : 8'h00) : adata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      susp_q  <= 1'b0;
      chip_q  <= 1'b0;
      tgt_q   <= '0;
      start_q <= 1'b0;
      op_q    <= OP_NONE;
      aaddr_q <= '0;
      adata_q <= '0;
    end else begin
      state_q <= state_d;
      susp_q  <= susp_d;
      chip_q  <= chip_d;
      tgt_q   <= tgt_d;
      start_q <= start_d;
      op_q    <= op_d;
      aaddr_q <= aaddr_d;
      adata_q <= adata_d;
    end
  end

  assign state     = state_q;
  assign susp      = susp_q;
  assign chip_tgt  = chip_q;
  assign tgt_addr  = tgt_q;
  assign alg_start = start_q;
  assign alg_op    = op_q;
  assign alg_addr  = aaddr_q;
  assign alg_data  = adata_q;
endmodule

// File: rtl/flash_rd_select.sv
module flash_rd_select
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 3
) (
  input  fsm_state_e        state,
  input  logic              susp,
  input  logic              chip_tgt,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output rd_src_e           rd_sel
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {{SECT_W{1'b1}}, {(ADDR_W-SECT_W){1'b0}}};

  logic in_tgt;

  always_comb begin
    in_tgt = chip_tgt || ((rd_addr & SECT_MASK) == (tgt_addr & SECT_MASK));
    unique case (state)
      ST_IDENT:                   rd_sel = RS_IDENT;
      ST_PROG, ST_ERASE, ST_ERR:  rd_sel = RS_STATUS;
      default:                    rd_sel = (susp && in_tgt) ? RS_STATUS : RS_ARRAY;
    endcase
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              alg_done,
  input  logic              alg_fail,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_sel,
  output logic              alg_start,
  output logic [1:0]        alg_op,
  output logic [ADDR_W-1:0] alg_addr,
  output logic [7:0]        alg_data,
  output logic              erase_hold,
  output logic              err_flag
);
  logic              rst_m, rst_q;
  wr_cls_t           cls;
  fsm_state_e        state;
  logic              susp, chip_tgt;
  logic [ADDR_W-1:0] tgt_addr;
  alg_op_e           op;
  rd_src_e           src;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(wr_addr), .data(wr_data), .cls(cls)
  );

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cls(cls), .alg_done(alg_done), .alg_fail(alg_fail),
    .state(state), .susp(susp), .chip_tgt(chip_tgt), .tgt_addr(tgt_addr),
    .alg_start(alg_start), .alg_op(op), .alg_addr(alg_addr), .alg_data(alg_data)
  );

  flash_rd_select #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rsel (
    .state(state), .susp(susp), .chip_tgt(chip_tgt), .tgt_addr(tgt_addr),
    .rd_addr(rd_addr), .rd_sel(src)
  );

  assign rd_sel     = src;
  assign alg_op     = op;
  assign erase_hold = susp;
  assign err_flag   = (state == ST_ERR);
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              alg_done,
  input logic [1:0]        rd_sel,
  input logic              alg_start,
  input logic [1:0]        alg_op,
  input logic              erase_hold,
  input logic              err_flag
);
  assert_busy_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alg_start |-> (rd_sel == 2'd1) && (alg_op != 2'd0));

  assert_start_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alg_start |-> $past(wr_en));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(wr_en && wr_data == 8'hF0)) |=> err_flag);

  assert_err_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> rd_sel == 2'd1);

  assert_hold_on_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_hold) |-> $past(wr_en && wr_data == 8'hB0));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !alg_done) |=> !alg_start && $stable(err_flag) && $stable(erase_hold));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_data(wr_data),
  .alg_done(alg_done), .rd_sel(rd_sel), .alg_start(alg_start),
  .alg_op(alg_op), .erase_hold(erase_hold), .err_flag(err_flag)
);

// File: tb/flash_cmd_fsm_test.sv
module flash_cmd_fsm_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          alg_done = 1'b0;
  logic          alg_fail = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_sel;
  logic          alg_start;
  logic [1:0]    alg_op;
  logic [AW-1:0] alg_addr;
  logic [7:0]    alg_data;
  logic          erase_hold;
  logic          err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(AW), .SECT_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alg_done(alg_done), .alg_fail(alg_fail),
    .rd_addr(rd_addr), .rd_sel(rd_sel), .alg_start(alg_start),
    .alg_op(alg_op), .alg_addr(alg_addr), .alg_data(alg_data),
    .erase_hold(erase_hold), .err_flag(err_flag)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done(bit fail);
    @(negedge clk);
    alg_done = 1'b1; alg_fail = fail;
    @(negedge clk);
    alg_done = 1'b0; alg_fail = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic rd_is(logic [AW-1:0] a, int exp, string req);
    rd_addr = a;
    #1;
    check(req, rd_sel, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rd_sel", rd_sel, 0);
    check("R1 err_flag", err_flag, 0);
    check("R1 erase_hold", erase_hold, 0);
    check("R1 alg_start", alg_start, 0);
  endtask

  task automatic t_program();
    unlock();
    wr(12'h0F0, 8'hA0);
    wr(12'h123, 8'h5A);
    check("R2 start", alg_start, 1);
    check("R2 op", alg_op, 1);
    check("R2 addr", alg_addr, 12'h123);
    check("R2 data", alg_data, 8'h5A);
    rd_is(12'h123, 1, "R2 busy status");
    @(negedge clk);
    check("R2 single pulse", alg_start, 0);
    done(1'b0);
    rd_is(12'h123, 0, "R2 back to array");
  endtask

  task automatic t_bad_seq();
    wr(12'h555, 8'hAA);
    wr(12'h2AB, 8'h55);
    wr(12'h555, 8'hA0);
    wr(12'h010, 8'h77);
    check("R3 wrong address no start", alg_start, 0);
    rd_is(12'h010, 0, "R3 read array");
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h54);
    wr(12'h2AA, 8'h55);
    wr(12'h555, 8'hA0);
    wr(12'h011, 8'h66);
    check("R3 wrong data no start", alg_start, 0);
  endtask

  task automatic t_reset_cmd();
    unlock();
    wr(12'h555, 8'h80);
    wr(12'h777, 8'hF0);
    unlock();
    wr(12'h555, 8'h10);
    check("R4 reset mid erase, chip cmd not taken", alg_start, 0);
    rd_is(12'h000, 0, "R4 read array after reset cmd");
    unlock();
    wr(12'h555, 8'hA0);
    wr(12'h020, 8'h11);
    check("R4 new sequence works after reset", alg_start, 1);
    done(1'b0);
  endtask

  task automatic t_chip_erase();
    unlock();
    wr(12'h555, 8'h80);
    unlock();
    wr(12'h555, 8'h10);
    check("R5 chip start", alg_start, 1);
    check("R5 chip op", alg_op, 3);
    wr(12'h000, 8'hB0);
    check("R6 hold after suspend", erase_hold, 1);
    rd_is(12'h100, 1, "R6 chip suspended, any addr status");
    rd_is(12'hF00, 1, "R6 chip suspended, top addr status");
    wr(12'h000, 8'h30);
    check("R6 hold cleared on resume", erase_hold, 0);
    done(1'b0);
    rd_is(12'h100, 0, "R5 chip erase done to array");
  endtask

  task automatic t_sector_suspend();
    unlock();
    wr(12'h555, 8'h80);
    unlock();
    wr(12'h400, 8'h30);
    check("R5 sector start", alg_start, 1);
    check("R5 sector op", alg_op, 2);
    check("R5 sector addr", alg_addr, 12'h400);
    wr(12'h000, 8'hB0);
    check("R6 hold", erase_hold, 1);
    rd_is(12'h500, 1, "R6 suspended sector status");
    rd_is(12'h100, 0, "R6 other sector array");
    unlock();
    wr(12'h555, 8'hA0);
    wr(12'h100, 8'h33);
    check("R7 program in suspend start", alg_start, 1);
    check("R7 program op", alg_op, 1);
    rd_is(12'h100, 1, "R7 busy status");
    done(1'b0);
    check("R7 hold kept", erase_hold, 1);
    rd_is(12'h500, 1, "R7 suspended sector status again");
    rd_is(12'h100, 0, "R7 other sector array again");
    wr(12'h000, 8'h30);
    check("R6 resume hold low", erase_hold, 0);
    rd_is(12'h100, 1, "R6 erase resumed status");
    done(1'b0);
    rd_is(12'h500, 0, "R6 erase done array");
  endtask

  task automatic t_ignore();
    wr(12'h400, 8'hB0);
    check("R8 B0 in read no hold", erase_hold, 0);
    rd_is(12'h400, 0, "R8 B0 in read stays array");
    wr(12'h400, 8'h30);
    rd_is(12'h400, 0, "R8 30 in read stays array");
    wr(12'h555, 8'hAA);
    wr(12'h123, 8'hB0);
    wr(12'h2AA, 8'h55);
    wr(12'h123, 8'h30);
    wr(12'h555, 8'hA0);
    wr(12'h222, 8'h44);
    check("R8 sequence survives ignored codes", alg_start, 1);
    check("R8 data", alg_data, 8'h44);
    done(1'b0);
  endtask

  task automatic t_ident();
    unlock();
    wr(12'h555, 8'h90);
    rd_is(12'h000, 2, "R9 ident mode");
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
    wr(12'h555, 8'hA0);
    rd_is(12'h001, 2, "R9 ident held through writes");
    wr(12'h003, 8'hF0);
    rd_is(12'h001, 0, "R9 reset leaves ident");
  endtask

  task automatic t_fail();
    unlock();
    wr(12'h555, 8'hA0);
    wr(12'h050, 8'h12);
    done(1'b1);
    check("R10 err set", err_flag, 1);
    rd_is(12'h050, 1, "R10 status on error");
    unlock();
    wr(12'h555, 8'hA0);
    check("R10 err held", err_flag, 1);
    wr(12'h060, 8'hF0);
    check("R10 err cleared", err_flag, 0);
    rd_is(12'h050, 0, "R10 array after clear");
  endtask

  task automatic t_busy();
    unlock();
    wr(12'h555, 8'hA0);
    wr(12'h070, 8'h99);
    wr(12'h000, 8'hF0);
    rd_is(12'h070, 1, "R11 reset ignored while busy");
    wr(12'h000, 8'hB0);
    check("R11 B0 ignored during program", erase_hold, 0);
    repeat (4) @(negedge clk);
    check("R12 idle no start", alg_start, 0);
    check("R12 idle err stable", err_flag, 0);
    rd_is(12'h070, 1, "R12 idle still busy");
    done(1'b0);
    rd_is(12'h070, 0, "R11 done to array");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_program();
    t_bad_seq();
    t_reset_cmd();
    t_chip_erase();
    t_sector_suspend();
    t_ignore();
    t_ident();
    t_fail();
    t_busy();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule